// File: doc/BRIEF.md
# Flash Bank Event Interrupt Aggregator

This block gathers completion and error events from the engines of four flash banks and merges them into one interrupt line. Each bank keeps its own status register and its own enable register. A status bit is set by a one-cycle pulse from that bank's engine. The bank's device-ready bit is set instead by a low-to-high edge on its ready/busy pin, which is first passed through a synchronizer.

Software reads and clears status through a small register port made of valid, write, address and data. A status bit is cleared by writing a one to it. A status bit is recorded whatever its enable says, so a masked source can still be polled. The interrupt line rises only when the global enable is set and some bank has a bit that is both pending and enabled.

Each bank's registers sit at address `bank*4`: offset 0 is status and offset 1 is enable. The global enable sits at address 16, bit 0. Every other address is reserved.

Top module: `nand_irq_ctrl`

## Requirements
- R1: There are four banks, each with an independent status register (address bank*4) and enable register (address bank*4+1). An event or write aimed at one bank leaves the registers of every other bank unchanged.
- R2: A pulse on `evt_pulse[bank*10+i]` sets status bit i of that bank at the next clock edge. The bit positions are: 0 page transfer done, 1 program complete, 2 program fail, 3 erase complete, 4 erase fail, 5 DMA command complete, 6 correctable ECC error, 7 uncorrectable ECC error, 8 erased page seen, 9 ECC transaction done.
- R3: Writing to a status address clears each bit written as one and leaves each bit written as zero unchanged. A status bit never falls for any other reason except reset.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R5: Status bits are recorded even when their enable bits are zero, and such bits do not raise `irq`.
- R6: A rising edge on `rb_in[bank]` sets status bit 10 of that bank on the third clock edge after the pin rises. A pin that stays high, or that falls, sets nothing.
- R7: `irq` is registered. One cycle after the state changes, it equals the global enable AND the OR, over all banks, of status AND enable.
- R8: While global enable bit 0 (address 16) is zero, `irq` stays low whatever is pending.
- R9: Writing 0x7FF to an enable register enables all eleven sources of that bank, and writing zero disables them all.
- R10: A read with `reg_valid`=1 and `reg_write`=0 returns, on the next cycle with `reg_rvalid`=1, the register value as it stood before that cycle's update. `reg_rvalid` is high only in that cycle.
- R11: After reset every status, enable and global bit is zero, and `irq` and `reg_rvalid` are low.
- R12: Writes to reserved addresses (offsets 2 and 3 of a bank, global offsets 1 to 3, bank fields 5 to 7) change nothing, and reads of them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 40 | One-cycle event pulses, ten per bank |
| rb_in | input | 4 | Asynchronous ready/busy pins, one per bank |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 11 | Write data |
| reg_rdata | output | 11 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read response strobe |
| irq | output | 1 | Merged interrupt line |

## Verification
The assertions check four things on every cycle: a pulsed bit is present after the edge, even against a same-cycle clear; a status bit only falls under a clearing write; `irq` is never high while the global enable is off or nothing enabled is pending; and read strobes pair one-to-one with read requests. Other behaviour can only be shown by the bench's scenarios. These are the three-edge latency of the ready/busy path and the fact that a steady or falling pin sets nothing. They also cover the independence of the banks, the reserved addresses and the exact read-before-update data. A cycle-accurate reference model covers the long random run.

// File: rtl/nand_irq_pkg.sv
package nand_irq_pkg;
  // number of pulse-driven event sources per bank
  localparam int SRC_COUNT = 10;

  // status bit positions
  localparam int BIT_XFER_DONE   = 0;
  localparam int BIT_PROG_OK     = 1;
  localparam int BIT_PROG_FAIL   = 2;
  localparam int BIT_ERASE_OK    = 3;
  localparam int BIT_ERASE_FAIL  = 4;
  localparam int BIT_DMA_DONE    = 5;
  localparam int BIT_ECC_FIXED   = 6;
  localparam int BIT_ECC_FATAL   = 7;
  localparam int BIT_BLANK_PAGE  = 8;
  localparam int BIT_ECC_DONE    = 9;
  localparam int BIT_DEV_READY   = SRC_COUNT;

  // register select inside a bank's four-word window
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_ENABLE = 2'd1
  } reg_sel_e;
endpackage

// File: rtl/irq_rb_sync.sv
module irq_rb_sync #(
  parameter int NUM_BANKS = 4,
  parameter int STAGES    = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_BANKS-1:0] rb_in,
  output logic [NUM_BANKS-1:0] rb_rise
);
  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bank
      // STAGES synchronizer flops plus one history flop for the edge
      logic [STAGES:0] sh;
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], rb_in[b]};
      end
      assign rb_rise[b] = sh[STAGES-1] & ~sh[STAGES];
    end
  endgenerate
endmodule

// File: rtl/irq_bank_regs.sv
module irq_bank_regs #(
  parameter int SRC_N  = 10,
  parameter int STAT_W = SRC_N + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SRC_N-1:0]  evt,
  input  logic              rb_rise,
  input  logic              wr_status,
  input  logic              wr_enable,
  input  logic [STAT_W-1:0] wdata,
  output logic [STAT_W-1:0] status,
  output logic [STAT_W-1:0] enable,
  output logic              pending
);
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;

  assign set_vec = {rb_rise, evt};
  assign clr_vec = wr_status ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      enable <= '0;
    end else begin
      // a new event outranks a same-cycle clear
      status <= (status & ~clr_vec) | set_vec;
      if (wr_enable) enable <= wdata;
    end
  end

  assign pending = |(status & enable);
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import nand_irq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int STAT_W    = 11,
  parameter int ADDR_W    = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        reg_valid,
  input  logic                        reg_write,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [NUM_BANKS*STAT_W-1:0] status_flat,
  input  logic [NUM_BANKS*STAT_W-1:0] enable_flat,
  input  logic                        glob_en,
  output logic [NUM_BANKS-1:0]        wr_status,
  output logic [NUM_BANKS-1:0]        wr_enable,
  output logic                        wr_global,
  output logic [STAT_W-1:0]           reg_rdata,
  output logic                        reg_rvalid
);
  localparam int BSEL_W = ADDR_W - 2;

  logic [BSEL_W-1:0] bank_idx;
  logic [1:0]        sel;
  logic              is_global;
  logic [STAT_W-1:0] rd_mux;

  assign bank_idx  = reg_addr[ADDR_W-1:2];
  assign sel       = reg_addr[1:0];
  assign is_global = (bank_idx == BSEL_W'(NUM_BANKS)) && (sel == SEL_STATUS);
  assign wr_global = reg_valid && reg_write && is_global;

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_dec
      logic hit;
      assign hit = reg_valid && reg_write && (bank_idx == BSEL_W'(b));
      assign wr_status[b] = hit && (sel == SEL_STATUS);
      assign wr_enable[b] = hit && (sel == SEL_ENABLE);
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    if (is_global) rd_mux = STAT_W'(glob_en);
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (bank_idx == BSEL_W'(i)) begin
        if (sel == SEL_STATUS)      rd_mux = status_flat[i*STAT_W +: STAT_W];
        else if (sel == SEL_ENABLE) rd_mux = enable_flat[i*STAT_W +: STAT_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_valid && !reg_write;
      if (reg_valid && !reg_write) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/nand_irq_ctrl.sv
module nand_irq_ctrl
  import nand_irq_pkg::*;
#(
  parameter  int NUM_BANKS   = 4,
  parameter  int SRC_N       = SRC_COUNT,
  parameter  int SYNC_STAGES = 2,
  localparam int STAT_W      = SRC_N + 1,
  localparam int ADDR_W      = $clog2(NUM_BANKS + 1) + 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_BANKS*SRC_N-1:0] evt_pulse,
  input  logic [NUM_BANKS-1:0]       rb_in,
  input  logic                       reg_valid,
  input  logic                       reg_write,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [STAT_W-1:0]          reg_wdata,
  output logic [STAT_W-1:0]          reg_rdata,
  output logic                       reg_rvalid,
  output logic                       irq
);
  logic [NUM_BANKS-1:0]        rb_rise;
  logic [NUM_BANKS-1:0]        wr_status;
  logic [NUM_BANKS-1:0]        wr_enable;
  logic [NUM_BANKS-1:0]        pending;
  logic                        wr_global;
  logic                        glob_en;
  logic [NUM_BANKS*STAT_W-1:0] status_flat;
  logic [NUM_BANKS*STAT_W-1:0] enable_flat;

  irq_rb_sync #(.NUM_BANKS(NUM_BANKS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .rb_in(rb_in), .rb_rise(rb_rise)
  );

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bank
      irq_bank_regs #(.SRC_N(SRC_N), .STAT_W(STAT_W)) u_regs (
        .clk(clk),
        .rst(rst),
        .evt(evt_pulse[b*SRC_N +: SRC_N]),
        .rb_rise(rb_rise[b]),
        .wr_status(wr_status[b]),
        .wr_enable(wr_enable[b]),
        .wdata(reg_wdata),
        .status(status_flat[b*STAT_W +: STAT_W]),
        .enable(enable_flat[b*STAT_W +: STAT_W]),
        .pending(pending[b])
      );
    end
  endgenerate

  irq_reg_port #(.NUM_BANKS(NUM_BANKS), .STAT_W(STAT_W), .ADDR_W(ADDR_W)) u_port (
    .clk(clk),
    .rst(rst),
    .reg_valid(reg_valid),
    .reg_write(reg_write),
    .reg_addr(reg_addr),
    .status_flat(status_flat),
    .enable_flat(enable_flat),
    .glob_en(glob_en),
    .wr_status(wr_status),
    .wr_enable(wr_enable),
    .wr_global(wr_global),
    .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      glob_en <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (wr_global) glob_en <= reg_wdata[0];
      irq <= glob_en && (|pending);
    end
  end
endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker #(
  parameter int NUM_BANKS = 4,
  parameter int SRC_N     = 10,
  parameter int STAT_W    = 11,
  parameter int ADDR_W    = 5
) (
  input logic                        clk,
  input logic                        rst,
  input logic [NUM_BANKS*SRC_N-1:0]  evt_pulse,
  input logic                        reg_valid,
  input logic                        reg_write,
  input logic [ADDR_W-1:0]           reg_addr,
  input logic [STAT_W-1:0]           reg_wdata,
  input logic                        reg_rvalid,
  input logic                        irq,
  input logic [NUM_BANKS*STAT_W-1:0] status_flat,
  input logic [NUM_BANKS*STAT_W-1:0] enable_flat,
  input logic                        glob_en
);
  logic [NUM_BANKS*STAT_W-1:0] evt_map;
  logic [NUM_BANKS*STAT_W-1:0] clr_map;

  always_comb begin
    evt_map = '0;
    clr_map = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      evt_map[i*STAT_W +: SRC_N] = evt_pulse[i*SRC_N +: SRC_N];
      if (reg_valid && reg_write && reg_addr[1:0] == 2'd0 &&
          reg_addr[ADDR_W-1:2] == (ADDR_W-2)'(i))
        clr_map[i*STAT_W +: STAT_W] = reg_wdata;
    end
  end

  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((status_flat & $past(evt_map)) == $past(evt_map)));

  assert_clear_only_by_write_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(status_flat) & ~status_flat & ~$past(clr_map)) == '0));

  assert_set_beats_clear_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(evt_map & clr_map) & ~status_flat) == '0));

  assert_irq_has_source_R7: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(status_flat & enable_flat)));

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(glob_en) |-> !irq);

  assert_read_answers_R10: assert property (@(posedge clk) disable iff (rst)
    (reg_valid && !reg_write) |=> reg_rvalid);

  assert_no_spurious_rvalid_R10: assert property (@(posedge clk) disable iff (rst)
    (reg_rvalid && !$past(rst)) |-> $past(reg_valid && !reg_write));
endmodule

bind nand_irq_ctrl irq_ctrl_checker #(
  .NUM_BANKS(NUM_BANKS), .SRC_N(SRC_N), .STAT_W(STAT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk),
  .rst(rst),
  .evt_pulse(evt_pulse),
  .reg_valid(reg_valid),
  .reg_write(reg_write),
  .reg_addr(reg_addr),
  .reg_wdata(reg_wdata),
  .reg_rvalid(reg_rvalid),
  .irq(irq),
  .status_flat(status_flat),
  .enable_flat(enable_flat),
  .glob_en(glob_en)
);

// File: tb/test_nand_irq_ctrl.sv
`timescale 1ns/1ps
module test_nand_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [39:0] evt_pulse = '0;
  logic [3:0]  rb_in = '0;
  logic        reg_valid = 1'b0;
  logic        reg_write = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [10:0] reg_wdata = '0;
  logic [10:0] reg_rdata;
  logic        reg_rvalid;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  nand_irq_ctrl i_nand_irq_ctrl (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .rb_in(rb_in),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [10:0] m_st [4];
  logic [10:0] m_en [4];
  logic        m_gen;
  bit          m_hist [4][3];   // pin samples: newest first
  logic        e_irq, e_rvalid;
  logic [10:0] e_rdata;

  function automatic logic [10:0] m_read(int a);
    int bk = a / 4;
    int of = a % 4;
    if (bk < 4 && of == 0) return m_st[bk];
    if (bk < 4 && of == 1) return m_en[bk];
    if (bk == 4 && of == 0) return {10'd0, m_gen};
    return 11'd0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin
        m_st[i] = '0; m_en[i] = '0;
        for (int k = 0; k < 3; k++) m_hist[i][k] = 1'b0;
      end
      m_gen = 1'b0; e_irq = 1'b0; e_rvalid = 1'b0; e_rdata = '0;
    end else begin
      logic any;
      int a;
      a = int'(reg_addr);
      any = 1'b0;
      for (int i = 0; i < 4; i++) any = any | (|(m_st[i] & m_en[i]));
      e_irq = m_gen & any;
      e_rvalid = reg_valid && !reg_write;
      if (e_rvalid) e_rdata = m_read(a);
      for (int i = 0; i < 4; i++) begin
        logic [10:0] setv, clrv;
        setv = {m_hist[i][1] & ~m_hist[i][2], evt_pulse[i*10 +: 10]};
        clrv = (reg_valid && reg_write && a == i*4) ? reg_wdata : 11'd0;
        m_st[i] = (m_st[i] & ~clrv) | setv;
        if (reg_valid && reg_write && a == i*4 + 1) m_en[i] = reg_wdata;
        m_hist[i][2] = m_hist[i][1];
        m_hist[i][1] = m_hist[i][0];
        m_hist[i][0] = rb_in[i];
      end
      if (reg_valid && reg_write && a == 16) m_gen = reg_wdata[0];
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R7 irq vs model", {31'd0, irq}, {31'd0, e_irq});
      chk("R10 rvalid vs model", {31'd0, reg_rvalid}, {31'd0, e_rvalid});
      if (e_rvalid) chk("R10 rdata vs model", {21'd0, reg_rdata}, {21'd0, e_rdata});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(bit v, bit w, int a, logic [10:0] d, logic [39:0] e);
    @(negedge clk);
    reg_valid = v; reg_write = w; reg_addr = 5'(a); reg_wdata = d; evt_pulse = e;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, '0, '0);
  endtask

  task automatic wr(int a, logic [10:0] d);
    tick(1, 1, a, d, '0);
  endtask

  task automatic rd(int a, output logic [10:0] d, input logic [39:0] e = '0);
    tick(1, 0, a, '0, e);
    tick(0, 0, 0, '0, '0);
    d = reg_rdata;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 200000) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<200000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [10:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11: reset state
    chk("R11 irq after reset", {31'd0, irq}, 32'd0);
    rd(0, d);  chk("R11 status0 after reset", d, 0);
    rd(16, d); chk("R11 global after reset", d, 0);

    // R9: enable all / none
    wr(1, 11'h7FF); rd(1, d); chk("R9 enable all ones", d, 11'h7FF);
    wr(1, 11'h000); rd(1, d); chk("R9 enable cleared", d, 0);

    // R2 and R5: event recorded while its enable is off
    wr(16, 11'h001);
    tick(0, 0, 0, '0, 40'd1 << 13);          // bank1 bit3 erase complete
    rd(4, d); chk("R2 bank1 erase-complete bit", d, 11'h008);
    idle(2);  chk("R5 masked source keeps irq low", {31'd0, irq}, 0);

    // R3: write-zero keeps, write-one clears
    wr(4, 11'h000); rd(4, d); chk("R3 write zero keeps bit", d, 11'h008);
    wr(4, 11'h008); rd(4, d); chk("R3 write one clears bit", d, 0);

    // R4: set and clear on the same bit in one cycle
    tick(1, 1, 8, 11'h001, 40'd1 << 20);     // bank2 bit0
    rd(8, d); chk("R4 set beats clear", d, 11'h001);

    // R1: other banks untouched
    rd(12, d); chk("R1 bank3 status untouched", d, 0);
    rd(0, d);  chk("R1 bank0 status untouched", d, 0);

    // R7: enabled pending bit raises irq
    wr(9, 11'h001); idle(2);
    chk("R7 irq with enabled pending bit", {31'd0, irq}, 1);

    // R8: global gate
    wr(16, 11'h000); idle(2);
    chk("R8 irq masked by global", {31'd0, irq}, 0);
    wr(16, 11'h001); idle(2);
    chk("R8 irq back with global", {31'd0, irq}, 1);
    wr(8, 11'h001); idle(2);
    chk("R7 irq drops after clear", {31'd0, irq}, 0);

    // R6: ready/busy rising edge
    idle(1); rb_in[1] = 1'b1;
    idle(5); rd(4, d); chk("R6 rising edge sets ready bit", d, 11'h400);
    wr(4, 11'h400);
    idle(5); rd(4, d); chk("R6 steady high sets nothing", d, 0);
    idle(1); rb_in[1] = 1'b0;
    idle(5); rd(4, d); chk("R6 falling edge sets nothing", d, 0);

    // R12: reserved addresses
    wr(2, 11'h7FF);  rd(2, d);  chk("R12 reserved read zero", d, 0);
    rd(1, d);        chk("R12 reserved write no effect on enable", d, 0);
    wr(20, 11'h7FF); rd(20, d); chk("R12 bank field 5 reads zero", d, 0);
    wr(17, 11'h000); rd(16, d); chk("R12 global offset 1 ignored", d, 11'h001);

    // R10: read returns value before same-cycle event
    rd(12, d, 40'd1 << 35);                  // bank3 bit5 pulses with the read
    chk("R10 read sees pre-update value", d, 0);
    rd(12, d); chk("R10 following read sees event", d, 11'h020);

    // random run, compared every cycle against the model
    for (int it = 0; it < 4000; it++) begin
      logic [39:0] e;
      int a;
      e = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      a = $urandom_range(0, 31);
      if ($urandom_range(0, 9) == 0) a = 16;
      if ($urandom_range(0, 7) == 0) rb_in = 4'($urandom);
      tick($urandom_range(0, 1), $urandom_range(0, 1), a, 11'($urandom), e);
    end
    idle(4);
    finish_run();
  end
endmodule